// File: doc/BRIEF.md
# Standby Mode Sequencer

This block sits beside a processor core and puts it into one of four standby states when the core executes its idle instruction. At the moment of that instruction it samples three configuration bits (power-down, stop-clock, stall). From them it picks a mode, then drops the matching clock enables: the core clock, the peripheral bus clock and the PLL run request. The mode stays in force until an interrupt is pending.

On a wake-up interrupt the sequencer first turns every clock back on. It then waits a fixed, mode-dependent number of cycles and pulses a resume strobe to the core. Two modes, Idle and Core power-down, keep the instruction pipeline. Two modes, Core/Peripheral power-down and All power-down, lose it. For those two the sequencer also pulses a pipeline-flush strobe in the same cycle as resume. Every clock enable is a flop that changes only on a state transition.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, core_clk_en, periph_clk_en and pll_run are 1, and resume and pipe_flush are 0.
- R2: Mode selection while running when idle_exec is 1, with bits taken in this order. All three bits set selects All power-down. Otherwise, stall=1 selects Idle. Otherwise, pd=1 with stck=1 selects Core/Peripheral. Otherwise, pd=1 selects Core. Idle leaves all three enables at 1.
- R3: Core mode sets core_clk_en=0, periph_clk_en=1 and pll_run=1 from the clock edge that sampled idle_exec.
- R4: Core/Peripheral mode sets core_clk_en=0, periph_clk_en=0 and pll_run=1 from that edge.
- R5: All power-down mode sets all three enables to 0 from that edge.
- R6: idle_exec with pd=0 and stall=0 is ignored. All enables stay 1, and a later interrupt produces no resume.
- R7: idle_exec is ignored while the block is asleep or waking. The enables and the wake timing are unchanged.
- R8: Take the edge that samples irq_pend=1 while asleep. From that edge all three enables are 1.
- R9: resume is a one-cycle pulse. It goes high L edges after the edge that sampled the interrupt, where L is 2 for Idle and Core, 6 for Core/Peripheral and 10 for All power-down.
- R10: pipe_flush pulses together with resume only on wake from Core/Peripheral or All power-down.
- R11: irq_pend while running produces no resume and no flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_exec | input | 1 | Core is executing the idle instruction |
| cfg_pd | input | 1 | Power-down configuration bit |
| cfg_stck | input | 1 | Stop-clock configuration bit |
| cfg_stall | input | 1 | Stall configuration bit |
| irq_pend | input | 1 | Wake-up interrupt pending |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral bus clock enable |
| pll_run | output | 1 | PLL keep-running request |
| pipe_flush | output | 1 | Pipeline must be refilled, pulses with resume |
| resume | output | 1 | Core may resume execution |

## Verification
The bench sweeps all eight configuration-bit combinations, each through a full entry and wake.

- **Decode priority.** A decoder with the wrong priority would gate the wrong clocks for overlapping bit patterns, for example stall with power-down.
- **Wake latency.** The bench counts edges from the interrupt to resume for each mode. A timer loaded one short, or with the wrong latency for the mode, moves resume by a cycle.
- **Nested idle during wake.** The bench issues a second idle instruction while the block is waking. A controller that honours it would drop clocks again or lose resume.
- **Idle with no mode.** The bench checks that an idle instruction with no mode selected leaves the block running, so that a stray interrupt cannot produce a resume.

// File: rtl/lpm_pkg.sv
// Package: shared mode, state and clock-enable types for the standby sequencer.
// Assumes a single clock domain; enables are consumed by external clock gates.
package lpm_pkg;

    typedef enum logic [2:0] {
        LPM_NONE,
        LPM_IDLE,
        LPM_CORE,
        LPM_CORE_PER,
        LPM_ALL
    } lpm_mode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_WAKE
    } lpm_state_e;

    typedef struct packed {
        logic core;
        logic periph;
        logic pll;
    } clk_en_t;

    // Clock enables held while asleep in the given mode.
    function automatic clk_en_t mode_clk_en(lpm_mode_e m);
        clk_en_t e;
        e = '{core: 1'b1, periph: 1'b1, pll: 1'b1};
        case (m)
            LPM_CORE:     e = '{core: 1'b0, periph: 1'b1, pll: 1'b1};
            LPM_CORE_PER: e = '{core: 1'b0, periph: 1'b0, pll: 1'b1};
            LPM_ALL:      e = '{core: 1'b0, periph: 1'b0, pll: 1'b0};
            default:      e = '{core: 1'b1, periph: 1'b1, pll: 1'b1};
        endcase
        return e;
    endfunction

    // True when the mode leaves the instruction pipeline intact.
    function automatic logic mode_keeps_pipe(lpm_mode_e m);
        return !(m == LPM_CORE_PER || m == LPM_ALL);
    endfunction

endpackage

// File: rtl/lpm_decode.sv
// Module: turns the three configuration bits into a standby mode.
// Priority: all bits set wins, then stall, then pd with stck, then pd alone.
// Assumes inputs are stable in the cycle idle_exec is sampled.
module lpm_decode
    import lpm_pkg::*;
(
    input  logic      pd,
    input  logic      stck,
    input  logic      stall,
    output lpm_mode_e mode
);

    // Priority decode of the configuration bits.
    always_comb begin
        if (pd && stck && stall)  mode = LPM_ALL;
        else if (stall)           mode = LPM_IDLE;
        else if (pd && stck)      mode = LPM_CORE_PER;
        else if (pd)              mode = LPM_CORE;
        else                      mode = LPM_NONE;
    end

endmodule

// File: rtl/lpm_wake_timer.sv
// Module: down-counter that measures the wake-up latency.
// Loaded with L on the interrupt edge; done is high while the count is 1,
// so the owner sees done on the L-th edge after loading. Assumes L >= 2.
module lpm_wake_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == CNT_W'(1));

    AST_LAT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val >= CNT_W'(2))); // R9

endmodule

// File: rtl/lpm_out_reg.sv
// Module: output flops for the clock enables and the wake strobes.
// Enables are computed from the next state so they change only together
// with a registered state transition, never from combinational glitches.
module lpm_out_reg
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lpm_state_e st_nxt,
    input  lpm_mode_e  mode_nxt,
    input  logic       fire,
    input  logic       keep_pipe,
    output logic       core_clk_en,
    output logic       periph_clk_en,
    output logic       pll_run,
    output logic       resume,
    output logic       pipe_flush
);

    clk_en_t en_nxt;

    // Select gated enables only while the next state is asleep.
    always_comb begin
        if (st_nxt == ST_SLEEP) en_nxt = mode_clk_en(mode_nxt);
        else                    en_nxt = '{core: 1'b1, periph: 1'b1, pll: 1'b1};
    end

    // Register enables and one-cycle wake strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_clk_en   <= 1'b1;
            periph_clk_en <= 1'b1;
            pll_run       <= 1'b1;
            resume        <= 1'b0;
            pipe_flush    <= 1'b0;
        end else begin
            core_clk_en   <= en_nxt.core;
            periph_clk_en <= en_nxt.periph;
            pll_run       <= en_nxt.pll;
            resume        <= fire;
            pipe_flush    <= fire && !keep_pipe;
        end
    end

    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume); // R9
    AST_FLUSH_WITH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |-> resume); // R10
    AST_RESUME_CLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (core_clk_en && periph_clk_en && pll_run)); // R8
    AST_PLL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_run |-> !periph_clk_en); // R5
    AST_PERIPH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_clk_en |-> !core_clk_en); // R4

endmodule

// File: rtl/lpm_ctrl.sv
// Module: standby mode sequencer top. Enters the decoded mode on idle_exec,
// waits for irq_pend, restores clocks, then after a mode-dependent latency
// pulses resume (and pipe_flush for modes that lose the pipeline).
// Assumes all latency parameters are at least 2.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int LAT_SHORT = 2,
    parameter int LAT_CP    = 6,
    parameter int LAT_ALL   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_exec,
    input  logic cfg_pd,
    input  logic cfg_stck,
    input  logic cfg_stall,
    input  logic irq_pend,
    output logic core_clk_en,
    output logic periph_clk_en,
    output logic pll_run,
    output logic pipe_flush,
    output logic resume
);

    localparam int LAT_MAX = (LAT_ALL > LAT_CP) ?
                             ((LAT_ALL > LAT_SHORT) ? LAT_ALL : LAT_SHORT) :
                             ((LAT_CP > LAT_SHORT) ? LAT_CP : LAT_SHORT);
    localparam int CNT_W = $clog2(LAT_MAX + 1);

    lpm_state_e       st_q, st_nxt;
    lpm_mode_e        mode_q, mode_nxt, dec_mode;
    logic             tmr_load, tmr_done, fire;
    logic [CNT_W-1:0] lat_val;

    lpm_decode u_decode (
        .pd    (cfg_pd),
        .stck  (cfg_stck),
        .stall (cfg_stall),
        .mode  (dec_mode)
    );

    // Wake latency for the mode being left.
    always_comb begin
        case (mode_q)
            LPM_CORE_PER: lat_val = CNT_W'(LAT_CP);
            LPM_ALL:      lat_val = CNT_W'(LAT_ALL);
            default:      lat_val = CNT_W'(LAT_SHORT);
        endcase
    end

    // Next-state logic of the run / sleep / wake sequence.
    always_comb begin
        st_nxt   = st_q;
        mode_nxt = mode_q;
        case (st_q)
            ST_RUN: begin
                if (idle_exec && dec_mode != LPM_NONE) begin
                    st_nxt   = ST_SLEEP;
                    mode_nxt = dec_mode;
                end
            end
            ST_SLEEP: if (irq_pend) st_nxt = ST_WAKE;
            ST_WAKE:  if (tmr_done) st_nxt = ST_RUN;
            default:  st_nxt = ST_RUN;
        endcase
    end

    assign tmr_load = (st_q == ST_SLEEP) && irq_pend;
    assign fire     = (st_q == ST_WAKE) && tmr_done;

    // State and captured mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            mode_q <= LPM_NONE;
        end else begin
            st_q   <= st_nxt;
            mode_q <= mode_nxt;
        end
    end

    lpm_wake_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (lat_val),
        .done     (tmr_done)
    );

    lpm_out_reg u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .st_nxt        (st_nxt),
        .mode_nxt      (mode_nxt),
        .fire          (fire),
        .keep_pipe     (mode_keeps_pipe(mode_q)),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .pll_run       (pll_run),
        .resume        (resume),
        .pipe_flush    (pipe_flush)
    );

    AST_SLEEP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && $past(st_q) == ST_RUN) |-> $past(idle_exec)); // R2
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN && $past(st_q) != ST_RUN) |-> $stable(mode_q)); // R7
    AST_RUN_NO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> !resume); // R11

endmodule

// File: tb/lpm_ctrl_tb_top.sv
// Bench: sweeps every configuration-bit pattern through entry and wake,
// computing expected enables and latencies from the requirements.
module lpm_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_exec = 1'b0, cfg_pd = 1'b0, cfg_stck = 1'b0, cfg_stall = 1'b0;
    logic irq_pend = 1'b0;
    logic core_clk_en, periph_clk_en, pll_run, pipe_flush, resume;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lpm_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .idle_exec     (idle_exec),
        .cfg_pd        (cfg_pd),
        .cfg_stck      (cfg_stck),
        .cfg_stall     (cfg_stall),
        .irq_pend      (irq_pend),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .pll_run       (pll_run),
        .pipe_flush    (pipe_flush),
        .resume        (resume)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // 0 none, 1 idle, 2 core, 3 core/per, 4 all (R2 priority)
    function automatic int exp_mode(input logic [2:0] b); // b = {pd, stck, stall}
        if (b == 3'b111) return 4;
        if (b[0])        return 1;
        if (b[2] && b[1]) return 3;
        if (b[2])        return 2;
        return 0;
    endfunction

    function automatic logic [2:0] exp_en(input int m); // {core, periph, pll}
        case (m)
            2: return 3'b011;
            3: return 3'b001;
            4: return 3'b000;
            default: return 3'b111;
        endcase
    endfunction

    function automatic int exp_lat(input int m);
        return (m == 3) ? 6 : (m == 4) ? 10 : 2;
    endfunction

    function automatic logic [2:0] en_now();
        return {core_clk_en, periph_clk_en, pll_run};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 enables", en_now(), 3'b111);
        check("R1 resume", resume, 1'b0);
        check("R1 flush", pipe_flush, 1'b0);

        // R11: interrupt while running does nothing.
        irq_pend = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); @(negedge clk);
            check("R11 resume", resume, 1'b0);
            check("R11 flush", pipe_flush, 1'b0);
        end
        irq_pend = 1'b0;

        for (int b = 0; b < 8; b++) begin
            int m;
            int lat;
            m = exp_mode(3'(b));
            lat = exp_lat(m);
            {cfg_pd, cfg_stck, cfg_stall} = 3'(b);
            idle_exec = 1'b1;
            @(posedge clk); @(negedge clk);
            idle_exec = 1'b0;
            {cfg_pd, cfg_stck, cfg_stall} = 3'b000;
            if (m == 0)      check("R6 enables", en_now(), 3'b111);
            else if (m == 1) check("R2 idle enables", en_now(), 3'b111);
            else if (m == 2) check("R3 core enables", en_now(), exp_en(m));
            else if (m == 3) check("R4 coreper enables", en_now(), exp_en(m));
            else             check("R5 all enables", en_now(), exp_en(m));

            if (m != 0) begin
                // R7: nested idle while asleep is ignored.
                {cfg_pd, cfg_stck, cfg_stall} = 3'b111;
                idle_exec = 1'b1;
                @(posedge clk); @(negedge clk);
                idle_exec = 1'b0;
                {cfg_pd, cfg_stck, cfg_stall} = 3'b000;
                check("R7 asleep enables", en_now(), exp_en(m));
                @(posedge clk); @(negedge clk);
            end

            irq_pend = 1'b1;
            @(posedge clk); @(negedge clk);
            irq_pend = 1'b0;
            if (m == 0) begin
                for (int k = 1; k <= 12; k++) begin
                    @(posedge clk); @(negedge clk);
                    check("R6 resume", resume, 1'b0);
                    check("R6 enables", en_now(), 3'b111);
                end
            end else begin
                check("R8 enables", en_now(), 3'b111);
                check("R9 resume early", resume, 1'b0);
                // R7: nested idle during wake is ignored.
                {cfg_pd, cfg_stck, cfg_stall} = 3'b111;
                idle_exec = 1'b1;
                for (int k = 1; k <= lat + 2; k++) begin
                    @(posedge clk); @(negedge clk);
                    idle_exec = 1'b0;
                    {cfg_pd, cfg_stck, cfg_stall} = 3'b000;
                    check("R9 resume", resume, (k == lat));
                    check("R10 flush", pipe_flush, (k == lat) && (m >= 3));
                    check("R7 wake enables", en_now(), 3'b111);
                end
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule